// File: doc/BRIEF.md
# Three-Port Bus Exchanger

This block joins three 16-bit ports, called A, B and C, so that data arriving on any one of them can be forwarded to either or both of the other two. Every port owns a storage element in front of the exchange fabric. The element can work in three ways:

- pass its input straight through,
- hold a value, or
- capture its input on a rising edge of the port's own clock, gated by an active-low clock enable.

Each port's output bus is fed from the storage output of one of its two peers, chosen by a one-bit select. An active-low output enable gates that output.

The block does not model a high-impedance bus directly. Instead each port gives a 16-bit data-out bus and a one-bit drive-enable flag, and the surrounding pad logic combines the two. The data-out bus always carries the selected value, even while the drive enable is low. A single asynchronous active-low reset clears all three storage elements. The reset is released separately in each port's clock domain.

Top module: `tri_port_exchanger`

## Requirements
- R1: The three ports are independent: a port's storage element changes only on its own data input, its own latch enable and its own clock, so clocking one port leaves the stored values of the other two untouched.
- R2: While a port's latch enable is 1, its storage output equals its data input in the same cycle, with no clock edge needed.
- R3: While latch enable is 0 and the port's clock is not toggling, the stored value stays put, whatever the data input and clock enable do.
- R4: With latch enable 0 and clock enable 0 (active low), the port's data input is captured on the next rising edge of that port's clock.
- R5: With latch enable 0 and clock enable 1, rising edges of the port clock leave the stored value unchanged.
- R6: Select encoding per port: port A selects B when sel=0 and C when sel=1; port B selects A when sel=0 and C when sel=1; port C selects A when sel=0 and B when sel=1. A single port's data may feed both other ports at once.
- R7: The drive enable of a port is the inverse of its output enable after reset, and the data-out bus carries the selected value whether or not the drive enable is set.
- R8: Asserting reset (rst_n=0) clears all storage to zero at once and drops every drive enable. After release, a port's drive enable returns at the second rising edge of that port's clock.
- R9: When latch enable falls, the stored value is the data present at the last rising edge of the port clock while latch enable was still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, shared by all ports |
| a_clk | input | 1 | Port A storage clock |
| a_din | input | 16 | Port A incoming data |
| a_le | input | 1 | Port A latch enable (1 = transparent) |
| a_clken_n | input | 1 | Port A active-low clock enable |
| a_sel | input | 1 | Port A source select |
| a_oe_n | input | 1 | Port A active-low output enable |
| a_dout | output | 16 | Port A outgoing data |
| a_drv_en | output | 1 | Port A drive enable |
| b_clk | input | 1 | Port B storage clock |
| b_din | input | 16 | Port B incoming data |
| b_le | input | 1 | Port B latch enable |
| b_clken_n | input | 1 | Port B active-low clock enable |
| b_sel | input | 1 | Port B source select |
| b_oe_n | input | 1 | Port B active-low output enable |
| b_dout | output | 16 | Port B outgoing data |
| b_drv_en | output | 1 | Port B drive enable |
| c_clk | input | 1 | Port C storage clock |
| c_din | input | 16 | Port C incoming data |
| c_le | input | 1 | Port C latch enable |
| c_clken_n | input | 1 | Port C active-low clock enable |
| c_sel | input | 1 | Port C source select |
| c_oe_n | input | 1 | Port C active-low output enable |
| c_dout | output | 16 | Port C outgoing data |
| c_drv_en | output | 1 | Port C drive enable |

## Verification
The bench walks a single one through every bit of port A in transparent mode and watches it arrive on B and C together. A design that wired the path with a bit swapped or fed only one peer would show a wrong word on one of the two outputs. It then stops A's clock with the clock enable asserted, to confirm that nothing is captured until a real rising edge arrives, and clocks B alone to show that A and C keep their contents. It also drives all six select combinations against three distinct stored words; any port whose select encoding was mirrored would return the wrong peer's word. Finally it asserts reset in mid-run, expecting the outputs to go to zero at once and the drive enables to come back only on the second clock edge after release; a design with a synchronous clear or a single-stage reset release would miss one of those cycles.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  localparam int NPORTS = 3;

  // Index of the peer picked by sel=0: first other port in A,B,C order.
  function automatic int first_peer(input int p);
    return (p == 0) ? 1 : 0;
  endfunction

  // Index of the peer picked by sel=1: second other port in A,B,C order.
  function automatic int second_peer(input int p);
    return (p == 2) ? 1 : 2;
  endfunction

endpackage

// File: rtl/xchg_rst_sync.sv
module xchg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // Shift a constant one through the chain once reset is released.
  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/xchg_store.sv
module xchg_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         clken_n,
  output logic [W-1:0] q
);

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         load;

  // The held register follows the input while transparent, and also loads
  // on an enabled clock edge while latched.
  always_comb begin
    load   = le | ~clken_n;
    hold_d = load ? din : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  // Transparent path bypasses the register combinationally.
  always_comb begin
    q = le ? din : hold_q;
  end

endmodule

// File: rtl/xchg_out_port.sv
module xchg_out_port #(
  parameter int W = 16
) (
  input  logic         rst_n,
  input  logic         sel,
  input  logic         oe_n,
  input  logic [W-1:0] peer0,
  input  logic [W-1:0] peer1,
  output logic [W-1:0] dout,
  output logic         drv_en
);

  always_comb begin
    dout   = sel ? peer1 : peer0;
    drv_en = rst_n & ~oe_n;
  end

endmodule

// File: rtl/tri_port_exchanger.sv
module tri_port_exchanger #(
  parameter int W = 16
) (
  input  logic         rst_n,
  input  logic         a_clk,
  input  logic [W-1:0] a_din,
  input  logic         a_le,
  input  logic         a_clken_n,
  input  logic         a_sel,
  input  logic         a_oe_n,
  output logic [W-1:0] a_dout,
  output logic         a_drv_en,
  input  logic         b_clk,
  input  logic [W-1:0] b_din,
  input  logic         b_le,
  input  logic         b_clken_n,
  input  logic         b_sel,
  input  logic         b_oe_n,
  output logic [W-1:0] b_dout,
  output logic         b_drv_en,
  input  logic         c_clk,
  input  logic [W-1:0] c_din,
  input  logic         c_le,
  input  logic         c_clken_n,
  input  logic         c_sel,
  input  logic         c_oe_n,
  output logic [W-1:0] c_dout,
  output logic         c_drv_en
);

  localparam int NP = xchg_pkg::NPORTS;

  logic [NP-1:0]        clk_v;
  logic [NP-1:0]        rst_sync_v;
  logic [NP-1:0][W-1:0] din_v;
  logic [NP-1:0]        le_v;
  logic [NP-1:0]        clken_n_v;
  logic [NP-1:0]        sel_v;
  logic [NP-1:0]        oe_n_v;
  logic [NP-1:0][W-1:0] q_v;
  logic [NP-1:0][W-1:0] dout_v;
  logic [NP-1:0]        drv_v;

  assign clk_v     = {c_clk, b_clk, a_clk};
  assign din_v     = {c_din, b_din, a_din};
  assign le_v      = {c_le, b_le, a_le};
  assign clken_n_v = {c_clken_n, b_clken_n, a_clken_n};
  assign sel_v     = {c_sel, b_sel, a_sel};
  assign oe_n_v    = {c_oe_n, b_oe_n, a_oe_n};

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int P0 = xchg_pkg::first_peer(p);
    localparam int P1 = xchg_pkg::second_peer(p);

    xchg_rst_sync #(.STAGES(2)) u_rst (
      .clk        (clk_v[p]),
      .rst_n      (rst_n),
      .rst_n_sync (rst_sync_v[p])
    );

    xchg_store #(.W(W)) u_store (
      .clk     (clk_v[p]),
      .rst_n   (rst_sync_v[p]),
      .din     (din_v[p]),
      .le      (le_v[p]),
      .clken_n (clken_n_v[p]),
      .q       (q_v[p])
    );

    xchg_out_port #(.W(W)) u_out (
      .rst_n  (rst_sync_v[p]),
      .sel    (sel_v[p]),
      .oe_n   (oe_n_v[p]),
      .peer0  (q_v[P0]),
      .peer1  (q_v[P1]),
      .dout   (dout_v[p]),
      .drv_en (drv_v[p])
    );
  end

  assign a_dout   = dout_v[0];
  assign b_dout   = dout_v[1];
  assign c_dout   = dout_v[2];
  assign a_drv_en = drv_v[0];
  assign b_drv_en = drv_v[1];
  assign c_drv_en = drv_v[2];

endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int W = 16
) (
  input logic [2:0]        clk_v,
  input logic [2:0]        rst_sync_v,
  input logic [2:0][W-1:0] din_v,
  input logic [2:0]        le_v,
  input logic [2:0]        clken_n_v,
  input logic [2:0]        sel_v,
  input logic [2:0]        oe_n_v,
  input logic [2:0][W-1:0] q_v,
  input logic [2:0][W-1:0] dout_v,
  input logic [2:0]        drv_v
);

  for (genvar p = 0; p < 3; p++) begin : g_chk
    localparam int P0 = xchg_pkg::first_peer(p);
    localparam int P1 = xchg_pkg::second_peer(p);

    // R4: enabled edge while latched captures the input
    a_r4_capture: assert property (@(posedge clk_v[p]) disable iff (!rst_sync_v[p])
      (!le_v[p] && !clken_n_v[p]) ##1 !le_v[p] |-> q_v[p] == $past(din_v[p]));

    // R5: disabled edges while latched keep the value
    a_r5_hold_disabled: assert property (@(posedge clk_v[p]) disable iff (!rst_sync_v[p])
      (!le_v[p] && clken_n_v[p]) ##1 !le_v[p] |-> $stable(q_v[p]));

    // R6: output carries the storage word of the selected peer
    a_r6_route: assert property (@(posedge clk_v[p]) disable iff (!rst_sync_v[p])
      dout_v[p] == (sel_v[p] ? q_v[P1] : q_v[P0]));

    // R2: a transparent peer reaches this output unchanged
    a_r2_passthrough: assert property (@(posedge clk_v[p]) disable iff (!rst_sync_v[p])
      (!sel_v[p] && le_v[P0]) |-> dout_v[p] == din_v[P0]);

    // R7: drive enable tracks the output enable once out of reset
    a_r7_drive: assert property (@(posedge clk_v[p]) disable iff (!rst_sync_v[p])
      drv_v[p] == !oe_n_v[p]);

    // R8: no drive while the port is held in reset
    a_r8_reset_quiet: assert property (@(posedge clk_v[p])
      !rst_sync_v[p] |-> !drv_v[p]);
  end

endmodule

bind tri_port_exchanger xchg_checker #(.W(W)) u_chk (
  .clk_v      (clk_v),
  .rst_sync_v (rst_sync_v),
  .din_v      (din_v),
  .le_v       (le_v),
  .clken_n_v  (clken_n_v),
  .sel_v      (sel_v),
  .oe_n_v     (oe_n_v),
  .q_v        (q_v),
  .dout_v     (dout_v),
  .drv_v      (drv_v)
);

// File: tb/tri_port_exchanger_tb.sv
`timescale 1ns/1ps
module tri_port_exchanger_tb;

  localparam int W = 16;

  logic clk;
  logic rst_n;
  logic [2:0] gate;
  logic a_le, b_le, c_le, a_ce, b_ce, c_ce, a_sel, b_sel, c_sel, a_oe, b_oe, c_oe;
  logic [W-1:0] a_din, b_din, c_din, a_dout, b_dout, c_dout;
  logic a_drv, b_drv, c_drv;
  logic a_clk, b_clk, c_clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  assign a_clk = clk & gate[0];
  assign b_clk = clk & gate[1];
  assign c_clk = clk & gate[2];

  tri_port_exchanger #(.W(W)) u_dut (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_din(a_din), .a_le(a_le), .a_clken_n(a_ce), .a_sel(a_sel),
    .a_oe_n(a_oe), .a_dout(a_dout), .a_drv_en(a_drv),
    .b_clk(b_clk), .b_din(b_din), .b_le(b_le), .b_clken_n(b_ce), .b_sel(b_sel),
    .b_oe_n(b_oe), .b_dout(b_dout), .b_drv_en(b_drv),
    .c_clk(c_clk), .c_din(c_din), .c_le(c_le), .c_clken_n(c_ce), .c_sel(c_sel),
    .c_oe_n(c_oe), .c_dout(c_dout), .c_drv_en(c_drv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] port_out(input int j);
    return (j == 0) ? a_dout : (j == 1) ? b_dout : c_dout;
  endfunction

  function automatic logic port_drv(input int j);
    return (j == 0) ? a_drv : (j == 1) ? b_drv : c_drv;
  endfunction

  task automatic set_sel(input int j, input logic s);
    if (j == 0) a_sel = s; else if (j == 1) b_sel = s; else c_sel = s;
  endtask

  task automatic set_oe(input int j, input logic v);
    if (j == 0) a_oe = v; else if (j == 1) b_oe = v; else c_oe = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] val [3];
    rst_n = 1'b0; gate = 3'b111;
    a_le = 0; b_le = 0; c_le = 0; a_ce = 1; b_ce = 1; c_ce = 1;
    a_sel = 0; b_sel = 0; c_sel = 0; a_oe = 0; b_oe = 0; c_oe = 0;
    a_din = '0; b_din = '0; c_din = '0;
    repeat (2) @(negedge clk);
    // R8: cleared, no drive during reset
    check("R8 a_dout in reset", a_dout, '0);
    check("R8 b_dout in reset", b_dout, '0);
    check("R8 c_dout in reset", c_dout, '0);
    check("R8 drive in reset", {13'd0, c_drv, b_drv, a_drv}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 drive after one edge", {13'd0, c_drv, b_drv, a_drv}, '0);
    @(negedge clk);
    check("R8 R7 drive after two edges", {13'd0, c_drv, b_drv, a_drv}, 16'd7);

    // R2 R6: transparent A to both B and C, walking one and its complement
    a_le = 1;
    for (int k = 0; k < W; k++) begin
      a_din = 16'(1) << k;
      #1;
      check("R2 walk to B", b_dout, 16'(1) << k);
      check("R6 walk to C", c_dout, 16'(1) << k);
      a_din = ~(16'(1) << k);
      #1;
      check("R2 inverse walk to B", b_dout, ~(16'(1) << k));
    end

    // R9: leaving transparent keeps value of last edge
    @(negedge clk); a_din = 16'h3C5A;
    @(negedge clk); a_le = 0; a_din = 16'hFFFF;
    #1; check("R9 held after le fall", b_dout, 16'h3C5A);
    // R5: edges with clock enable high change nothing
    repeat (3) @(negedge clk);
    check("R5 disabled edges", b_dout, 16'h3C5A);
    // R3: clock stopped, enable asserted, still held
    gate[0] = 0; a_ce = 0; a_din = 16'h0F0F;
    repeat (3) @(negedge clk);
    check("R3 steady clock holds", b_dout, 16'h3C5A);
    // R4: first real edge captures
    gate[0] = 1;
    @(negedge clk);
    check("R4 capture on edge", b_dout, 16'h0F0F);
    a_ce = 1;

    // R1: clock B alone, A and C untouched
    gate = 3'b010; b_ce = 0; b_din = 16'h1234; a_sel = 0; c_sel = 1;
    #1; check("R1 B before its edge", a_dout, 16'h0000);
    @(negedge clk);
    check("R1 R4 B captured", a_dout, 16'h1234);
    c_sel = 0; #1;
    check("R1 A unchanged", c_dout, 16'h0F0F);
    b_ce = 1; gate = 3'b111;

    // R6: full select sweep with distinct stored words
    val[0] = 16'h1111; val[1] = 16'h2222; val[2] = 16'h3333;
    a_din = val[0]; b_din = val[1]; c_din = val[2];
    a_le = 1; b_le = 1; c_le = 1;
    @(negedge clk); a_le = 0; b_le = 0; c_le = 0;
    a_din = '0; b_din = '0; c_din = '0;
    for (int j = 0; j < 3; j++) begin
      for (int s = 0; s < 2; s++) begin
        int pe;
        pe = (j == 0) ? (s ? 2 : 1) : (j == 1) ? (s ? 2 : 0) : (s ? 1 : 0);
        set_sel(j, s[0]);
        #1;
        check($sformatf("R6 port %0d sel %0d", j, s), port_out(j), val[pe]);
      end
    end

    // R7: output enable gates drive only
    for (int j = 0; j < 3; j++) begin
      set_oe(j, 1'b1); #1;
      check($sformatf("R7 port %0d off", j), {15'd0, port_drv(j)}, 16'd0);
      check($sformatf("R7 port %0d data while off", j), port_out(j),
            (j == 0) ? val[2] : (j == 1) ? val[2] : val[1]);
      set_oe(j, 1'b0); #1;
      check($sformatf("R7 port %0d on", j), {15'd0, port_drv(j)}, 16'd1);
    end

    // R8: mid-run reset clears immediately
    @(negedge clk); rst_n = 0; #1;
    check("R8 mid reset A", a_dout, '0);
    check("R8 mid reset C", c_dout, '0);
    check("R8 mid reset drive", {13'd0, c_drv, b_drv, a_drv}, '0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    check("R8 drive restored", {13'd0, c_drv, b_drv, a_drv}, 16'd7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule